// File: doc/BRIEF.md
# Integer Execution ALU

This block is the combinational arithmetic and logic unit of a small register-based processor core. It receives two 32-bit operands and a 5-bit operation code, and it returns a single 32-bit result. The second operand is prepared upstream. It is either a register value, a sign-extended 12-bit immediate (range -2048..2047), or a zero-extended 5-bit shift count. Decoding, register access, condition flags and pipeline control live outside this block.

The unit covers the following operations:
- addition and subtraction; negation is issued as zero minus the operand;
- the low product, plus three high-product forms: signed by signed, unsigned by unsigned, and signed first operand by unsigned second operand;
- signed truncating division and its remainder;
- six bitwise operations; bitwise inversion is issued as XOR with all ones;
- left and right logical shifts, an arithmetic right shift, and rotations in both directions.

A single shared multiplier serves all four product forms. A magnitude divider serves both quotient and remainder.

Top module: `xalu_core`

## Requirements
- R1: Code 0 (ADD) gives (a + b) mod 2^32, so a sum that overflows wraps around.
- R2: Code 1 (SUB) gives (a - b) mod 2^32, so 0 - b is the two's-complement negation of b.
- R3: Code 2 (MUL) gives the low 32 bits of the 64-bit product a*b.
- R4: Code 3 (MULHSS) gives the upper 32 bits of the product of signed a and signed b.
- R5: Code 4 (MULHUU) gives the upper 32 bits of the product of unsigned a and unsigned b.
- R6: Code 5 (MULHSU) gives the upper 32 bits of the product of signed a and unsigned b.
- R7: Code 6 (DIV) gives the signed quotient a/b, truncated toward zero. When b is 0 it gives 0xFFFFFFFF. When a is 0x80000000 and b is -1 it gives 0x80000000.
- R8: Code 7 (REM) gives the signed remainder, which carries the sign of a and satisfies a = q*b + r. When b is 0 it gives a. When a is 0x80000000 and b is -1 it gives 0.
- R9: Codes 8..13 give the bitwise AND, OR, XOR, NAND, NOR and XNOR of a and b, in that order. XOR with b = 0xFFFFFFFF gives ~a.
- R10: Codes 14, 15 and 16 give a shifted left logically, right logically and right arithmetically. The shift count is b[4:0], and b[31:5] has no effect.
- R11: Codes 17 and 18 rotate a left and right by b[4:0] places. A count of 0 returns a unchanged.
- R12: Every code from 19 to 31 gives a result of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 5 | Operation code |
| opnd_a | input | 32 | First operand (dividend, value being shifted) |
| opnd_b | input | 32 | Second operand (register or prepared immediate) |
| result | output | 32 | Result of the selected operation |

## Verification
The unit has no registers, so every result is due in the same cycle in which the operands and the code are presented. The bench changes its inputs just after a rising edge and samples `result` at the following falling edge, half a period later. By then the combinational paths have settled, and no sample can depend on the order of processes at an edge. Each code is swept over a grid of corner operands that includes zero, one, minus one, the two extreme values, alternating bit patterns and counts with high garbage bits. Random operand pairs are then added for every code.

// File: rtl/xalu_pkg.sv
package xalu_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD    = 5'd0,
        OP_SUB    = 5'd1,
        OP_MUL    = 5'd2,
        OP_MULHSS = 5'd3,
        OP_MULHUU = 5'd4,
        OP_MULHSU = 5'd5,
        OP_DIV    = 5'd6,
        OP_REM    = 5'd7,
        OP_AND    = 5'd8,
        OP_OR     = 5'd9,
        OP_XOR    = 5'd10,
        OP_NAND   = 5'd11,
        OP_NOR    = 5'd12,
        OP_XNOR   = 5'd13,
        OP_SLL    = 5'd14,
        OP_SRL    = 5'd15,
        OP_SRA    = 5'd16,
        OP_ROL    = 5'd17,
        OP_ROR    = 5'd18
    } alu_op_e;

    typedef enum logic [2:0] {
        LG_AND, LG_OR, LG_XOR, LG_NAND, LG_NOR, LG_XNOR
    } logic_fn_e;

    typedef enum logic [2:0] {
        SH_LL, SH_RL, SH_RA, SH_OL, SH_OR
    } shift_fn_e;

endpackage

// File: rtl/xalu_mul.sv
module xalu_mul #(
    parameter int W = 32
) (
    input  logic         a_signed,
    input  logic         b_signed,
    input  logic         take_high,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] prod
);
    localparam int PW = 2 * W;

    logic [PW-1:0] ext_a;
    logic [PW-1:0] ext_b;
    logic [PW-1:0] full;

    // Extending each operand to double width lets one unsigned multiplier
    // produce every signedness variant modulo 2^(2W).
    always_comb begin
        ext_a = {{W{a_signed & a[W-1]}}, a};
        ext_b = {{W{b_signed & b[W-1]}}, b};
        full  = ext_a * ext_b;
        prod  = take_high ? full[PW-1:W] : full[W-1:0];
    end

endmodule

// File: rtl/xalu_div.sv
module xalu_div #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] quot,
    output logic [W-1:0] rem
);
    logic          neg_a;
    logic          neg_b;
    logic [W-1:0]  mag_a;
    logic [W-1:0]  mag_b;
    logic [W-1:0]  mag_q;
    logic [W-1:0]  mag_r;
    logic          div_zero;

    always_comb begin
        neg_a    = a[W-1];
        neg_b    = b[W-1];
        mag_a    = neg_a ? (~a + 1'b1) : a;
        mag_b    = neg_b ? (~b + 1'b1) : b;
        div_zero = (b == '0);
        mag_q    = div_zero ? '0 : (mag_a / mag_b);
        mag_r    = div_zero ? '0 : (mag_a % mag_b);
        if (div_zero) begin
            quot = '1;
            rem  = a;
        end else begin
            // The most negative value over -1 wraps back to itself here.
            quot = (neg_a ^ neg_b) ? (~mag_q + 1'b1) : mag_q;
            rem  = neg_a ? (~mag_r + 1'b1) : mag_r;
        end
    end

endmodule

// File: rtl/xalu_logic.sv
module xalu_logic #(
    parameter int W = 32
) (
    input  xalu_pkg::logic_fn_e fn,
    input  logic [W-1:0]        a,
    input  logic [W-1:0]        b,
    output logic [W-1:0]        y
);
    import xalu_pkg::*;

    logic invert;
    logic [W-1:0] base;

    assign invert = (fn == LG_NAND) || (fn == LG_NOR) || (fn == LG_XNOR);

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            unique case (fn)
                LG_AND, LG_NAND: base[i] = a[i] & b[i];
                LG_OR,  LG_NOR:  base[i] = a[i] | b[i];
                default:         base[i] = a[i] ^ b[i];
            endcase
            y[i] = base[i] ^ invert;
        end
    end

endmodule

// File: rtl/xalu_shift.sv
module xalu_shift #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  xalu_pkg::shift_fn_e fn,
    input  logic [W-1:0]        a,
    input  logic [SW-1:0]       amt,
    output logic [W-1:0]        y
);
    import xalu_pkg::*;

    logic [2*W-1:0] dbl;
    logic [2*W-1:0] rot_l;
    logic [2*W-1:0] rot_r;

    always_comb begin
        dbl   = {a, a};
        rot_l = dbl << amt;
        rot_r = dbl >> amt;
        unique case (fn)
            SH_LL:   y = a << amt;
            SH_RL:   y = a >> amt;
            SH_RA:   y = $unsigned($signed(a) >>> amt);
            SH_OL:   y = rot_l[2*W-1:W];
            default: y = rot_r[W-1:0];
        endcase
    end

endmodule

// File: rtl/xalu_core.sv
module xalu_core #(
    parameter int W = 32
) (
    input  logic [4:0]   op_sel,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic [W-1:0] result
);
    import xalu_pkg::*;

    localparam int SW = $clog2(W);

    alu_op_e   op;
    logic      mul_a_s;
    logic      mul_b_s;
    logic      mul_hi;
    logic_fn_e lg_fn;
    shift_fn_e sh_fn;

    logic [W-1:0] sum;
    logic [W-1:0] diff;
    logic [W-1:0] prod;
    logic [W-1:0] quot;
    logic [W-1:0] rem;
    logic [W-1:0] lg_y;
    logic [W-1:0] sh_y;

    assign op = alu_op_e'(op_sel);

    always_comb begin
        mul_a_s = (op == OP_MULHSS) || (op == OP_MULHSU);
        mul_b_s = (op == OP_MULHSS);
        mul_hi  = (op == OP_MULHSS) || (op == OP_MULHUU) || (op == OP_MULHSU);
        unique case (op)
            OP_OR:   lg_fn = LG_OR;
            OP_XOR:  lg_fn = LG_XOR;
            OP_NAND: lg_fn = LG_NAND;
            OP_NOR:  lg_fn = LG_NOR;
            OP_XNOR: lg_fn = LG_XNOR;
            default: lg_fn = LG_AND;
        endcase
        unique case (op)
            OP_SRL:  sh_fn = SH_RL;
            OP_SRA:  sh_fn = SH_RA;
            OP_ROL:  sh_fn = SH_OL;
            OP_ROR:  sh_fn = SH_OR;
            default: sh_fn = SH_LL;
        endcase
    end

    assign sum  = opnd_a + opnd_b;
    assign diff = opnd_a - opnd_b;

    xalu_mul #(.W(W)) u_mul (
        .a_signed (mul_a_s),
        .b_signed (mul_b_s),
        .take_high(mul_hi),
        .a        (opnd_a),
        .b        (opnd_b),
        .prod     (prod)
    );

    xalu_div #(.W(W)) u_div (
        .a   (opnd_a),
        .b   (opnd_b),
        .quot(quot),
        .rem (rem)
    );

    xalu_logic #(.W(W)) u_logic (
        .fn(lg_fn),
        .a (opnd_a),
        .b (opnd_b),
        .y (lg_y)
    );

    xalu_shift #(.W(W), .SW(SW)) u_shift (
        .fn (sh_fn),
        .a  (opnd_a),
        .amt(opnd_b[SW-1:0]),
        .y  (sh_y)
    );

    always_comb begin
        unique case (op_sel)
            OP_ADD:                                  result = sum;
            OP_SUB:                                  result = diff;
            OP_MUL, OP_MULHSS, OP_MULHUU, OP_MULHSU: result = prod;
            OP_DIV:                                  result = quot;
            OP_REM:                                  result = rem;
            OP_AND, OP_OR, OP_XOR,
            OP_NAND, OP_NOR, OP_XNOR:                result = lg_y;
            OP_SLL, OP_SRL, OP_SRA, OP_ROL, OP_ROR:  result = sh_y;
            default:                                 result = '0;
        endcase
    end

endmodule

// File: rtl/xalu_checker.sv
module xalu_checker #(
    parameter int W = 32
) (
    input logic [4:0]   op_sel,
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic [W-1:0] result
);
    always_comb begin
        if (op_sel == 5'd0) begin
            AST_ADD_UNDO: assert (result - opnd_b == opnd_a); // R1
        end
        if (op_sel == 5'd1) begin
            AST_SUB_UNDO: assert (result + opnd_b == opnd_a); // R2
        end
        if (op_sel == 5'd6 && opnd_b == '0) begin
            AST_DIV_BY_ZERO: assert (result == '1); // R7
        end
        if (op_sel == 5'd7 && result != '0) begin
            AST_REM_SIGN: assert (result[W-1] == opnd_a[W-1]); // R8
        end
        if (op_sel == 5'd11) begin
            AST_NAND_DISJOINT: assert ((result & opnd_a & opnd_b) == '0); // R9
        end
        if ((op_sel == 5'd17 || op_sel == 5'd18) && opnd_b[4:0] == 5'd0) begin
            AST_ROT_ZERO: assert (result == opnd_a); // R11
        end
        if (op_sel == 5'd17 || op_sel == 5'd18) begin
            AST_ROT_POPCOUNT: assert ($countones(result) == $countones(opnd_a)); // R11
        end
        if (op_sel > 5'd18) begin
            AST_UNUSED_ZERO: assert (result == '0); // R12
        end
    end
endmodule

bind xalu_core xalu_checker #(.W(W)) u_xalu_checker (
    .op_sel(op_sel),
    .opnd_a(opnd_a),
    .opnd_b(opnd_b),
    .result(result)
);

// File: tb/xalu_core_bench.sv
`timescale 1ns/1ps
module xalu_core_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op_sel = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    xalu_core u_xalu_core (
        .op_sel(op_sel),
        .opnd_a(opnd_a),
        .opnd_b(opnd_b),
        .result(result)
    );

    function automatic string req_of(input logic [4:0] op);
        case (op)
            5'd0: return "R1";
            5'd1: return "R2";
            5'd2: return "R3";
            5'd3: return "R4";
            5'd4: return "R5";
            5'd5: return "R6";
            5'd6: return "R7";
            5'd7: return "R8";
            5'd8, 5'd9, 5'd10, 5'd11, 5'd12, 5'd13: return "R9";
            5'd14, 5'd15, 5'd16: return "R10";
            5'd17, 5'd18: return "R11";
            default: return "R12";
        endcase
    endfunction

    function automatic logic [31:0] model(input logic [4:0] op,
                                          input logic [31:0] a,
                                          input logic [31:0] b);
        longint sa, sb, q, r;
        logic [63:0] p;
        logic [31:0] y;
        int s;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        s  = int'(b[4:0]);
        y  = '0;
        case (op)
            5'd0: y = 32'(sa + sb);
            5'd1: y = 32'(sa - sb);
            5'd2: begin p = 64'(sa * sb); y = p[31:0]; end
            5'd3: begin p = 64'(sa * sb); y = p[63:32]; end
            5'd4: begin p = {32'd0, a} * {32'd0, b}; y = p[63:32]; end
            5'd5: begin p = 64'(sa * longint'({32'd0, b})); y = p[63:32]; end
            5'd6: begin
                if (b == 0) y = 32'hFFFF_FFFF;
                else begin q = sa / sb; y = 32'(q); end
            end
            5'd7: begin
                if (b == 0) y = a;
                else begin q = sa / sb; r = sa - q * sb; y = 32'(r); end
            end
            5'd8:  y = a & b;
            5'd9:  y = a | b;
            5'd10: y = a ^ b;
            5'd11: y = ~(a & b);
            5'd12: y = ~(a | b);
            5'd13: y = ~(a ^ b);
            5'd14: for (int i = 0; i < 32; i++) if (i >= s) y[i] = a[i - s];
            5'd15: for (int i = 0; i < 32; i++) if (i + s < 32) y[i] = a[i + s];
            5'd16: for (int i = 0; i < 32; i++) y[i] = (i + s < 32) ? a[i + s] : a[31];
            5'd17: for (int i = 0; i < 32; i++) y[(i + s) % 32] = a[i];
            5'd18: for (int i = 0; i < 32; i++) y[i] = a[(i + s) % 32];
            default: y = '0;
        endcase
        return y;
    endfunction

    task automatic apply_check(input logic [4:0] op, input logic [31:0] a,
                               input logic [31:0] b);
        logic [31:0] exp;
        @(posedge clk);
        #0.5;
        op_sel = op;
        opnd_a = a;
        opnd_b = b;
        exp = model(op, a, b);
        @(negedge clk);
        checks++;
        if (result !== exp) begin
            errors++;
            $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h",
                     req_of(op), op, a, b, result, exp);
        end
    endtask

    task automatic fixed(input string req, input logic [4:0] op,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] exp);
        @(posedge clk);
        #0.5;
        op_sel = op;
        opnd_a = a;
        opnd_b = b;
        @(negedge clk);
        checks++;
        if (result !== exp) begin
            errors++;
            $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h",
                     req, op, a, b, result, exp);
        end
    endtask

    logic [31:0] corner [12];

    initial begin
        corner[0]  = 32'h0000_0000;
        corner[1]  = 32'h0000_0001;
        corner[2]  = 32'hFFFF_FFFF;
        corner[3]  = 32'h8000_0000;
        corner[4]  = 32'h7FFF_FFFF;
        corner[5]  = 32'hAAAA_AAAA;
        corner[6]  = 32'h5555_5555;
        corner[7]  = 32'h0000_0007;
        corner[8]  = 32'hFFFF_F800;
        corner[9]  = 32'h0000_07FF;
        corner[10] = 32'hFFFF_FFE3;
        corner[11] = 32'h1234_5660;

        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Idle state: code 0 with zero operands gives zero (R1).
        fixed("R1", 5'd0, 32'd0, 32'd0, 32'd0);
        // Directed boundary cases.
        fixed("R1", 5'd0, 32'h7FFF_FFFF, 32'd1, 32'h8000_0000);
        fixed("R2", 5'd1, 32'd0, 32'd5, 32'hFFFF_FFFB);
        fixed("R4", 5'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0);
        fixed("R5", 5'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFE);
        fixed("R6", 5'd5, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        fixed("R7", 5'd6, 32'hFFFF_FFF9, 32'd2, 32'hFFFF_FFFD);
        fixed("R7", 5'd6, 32'h8000_0000, 32'hFFFF_FFFF, 32'h8000_0000);
        fixed("R7", 5'd6, 32'd9, 32'd0, 32'hFFFF_FFFF);
        fixed("R8", 5'd7, 32'hFFFF_FFF9, 32'd2, 32'hFFFF_FFFF);
        fixed("R8", 5'd7, 32'h8000_0000, 32'hFFFF_FFFF, 32'd0);
        fixed("R8", 5'd7, 32'd9, 32'd0, 32'd9);
        fixed("R9", 5'd10, 32'h0F0F_1234, 32'hFFFF_FFFF, 32'hF0F0_EDCB);
        fixed("R10", 5'd14, 32'd1, 32'hFFFF_FFE4, 32'h0000_0010);
        fixed("R10", 5'd16, 32'h8000_0000, 32'd31, 32'hFFFF_FFFF);
        fixed("R11", 5'd17, 32'h8000_0001, 32'd1, 32'h0000_0003);
        fixed("R11", 5'd18, 32'h8000_0001, 32'd1, 32'hC000_0000);
        fixed("R12", 5'd31, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0);

        // Sweep every code over the corner grid, then random pairs.
        for (int op = 0; op < 32; op++) begin
            for (int i = 0; i < 12; i++)
                for (int j = 0; j < 12; j++)
                    apply_check(5'(op), corner[i], corner[j]);
            for (int k = 0; k < 150; k++)
                apply_check(5'(op), $urandom, $urandom);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule